// File: doc/BRIEF.md
# Per-Block Integer Quantizer

This block turns a stream of signed 16-bit fixed-point values into 8-bit integer codes. It cuts the stream into contiguous blocks of `BLOCK_LEN` elements (16, 32 or 128) and gives each block its own scale. Because of this, a large value changes the resolution of its own block and of no other block. The element that opens a block carries a start marker. The mapping mode is sampled on that element. Symmetric mode gives signed codes centred on zero. Asymmetric mode gives unsigned codes that run from the block minimum to the block maximum, plus a zero-point code.

The block works in two phases. First it stores the whole block and tracks its smallest and largest values. It then drops `inReady` and drains the block. It emits one metadata beat that carries the scale span and the zero-point. After that beat come the codes, in input order. A bit-serial divider computes each code as a rounded quotient. The scale reported is the span: the largest magnitude in symmetric mode, or max minus min in asymmetric mode. One code step therefore equals span/127 in symmetric mode and span/255 in asymmetric mode.

Top module: `block_quantizer`

## Requirements
- R1: An accepted element with `inFirst`=1 becomes element 0 of a new block, and any partly filled block is discarded. The next `BLOCK_LEN`-1 accepted elements complete the block. Elements accepted with `inFirst`=0 while no block is open are discarded.
- R2: Symmetric mode (`asymMode`=0). `metaScale` is max|x| over the block as a 17-bit unsigned value, and `metaZero` is 0. Each code is round(x*127/metaScale), rounded half away from zero and given as 8-bit two's complement.
- R3: Symmetric codes stay in -127..+127. The code 0x80 (-128) never appears.
- R4: Asymmetric mode (`asymMode`=1). `metaScale` is max-min, and each code is the unsigned value round((x-min)*255/metaScale), rounded half up. The block minimum maps to 0 and the block maximum maps to 255.
- R5: In asymmetric mode, `metaZero` is 0 when min >= 0. Otherwise it is round(-min*255/span), saturated to 255.
- R6: A block with zero span reports `metaScale`=0 and `metaZero`=0, and all its codes are 0. This covers an all-zero block in symmetric mode and a block of equal values in asymmetric mode.
- R7: The mode in force is the `asymMode` value sampled with the block's first element. Its value on the later elements has no effect.
- R8: A block's scale and codes depend only on its own elements. An outlier in one block leaves the next block's results unchanged.
- R9: For each block, `metaValid` pulses once before the first code. Exactly `BLOCK_LEN` codes then follow in input order, and `outLast` is set on the last one.
- R10: `inReady` is low from the cycle after the block's final element is accepted until the last code is presented. In particular, it is low whenever `metaValid` is high or a code other than the last is presented.
- R11: After reset, `inReady`=1, `metaValid`=0 and `outValid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| asymMode | input | 1 | Mapping mode, sampled with the first element of a block (1 = asymmetric) |
| inValid | input | 1 | Input element valid |
| inFirst | input | 1 | Marks the first element of a block |
| inData | input | 16 | Signed fixed-point input element |
| inReady | output | 1 | Input accepted on this cycle when high together with `inValid` |
| metaValid | output | 1 | One-cycle pulse carrying the block metadata |
| metaScale | output | 17 | Block span: max magnitude (symmetric) or max-min (asymmetric) |
| metaZero | output | 8 | Zero-point code (asymmetric), 0 in symmetric mode |
| outValid | output | 1 | Code valid |
| outCode | output | 8 | Quantized code |
| outLast | output | 1 | Marks the last code of a block |

## Verification
A wrong extreme register or a wrong mode latch appears in that block's `metaScale` on its metadata beat. It then skews every code of the block. A slip in the write or read index shows up as a code whose value belongs to a neighbouring element, or as `outLast` on the wrong beat. Both are caught within one block of the cause. Faults in the divider or in the rounding show as off-by-one codes at exact half steps. The directed half-step and full-range blocks target these.

// File: rtl/qb_pkg.sv
package qb_pkg;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic capture;    // store inData into the block buffer
    logic restart;    // captured element starts a new block
    logic startZp;    // launch zero-point division
    logic latchZp;    // store zero-point quotient
    logic emitMeta;   // present block metadata
    logic startCode;  // launch division for the current element
    logic emitCode;   // present a code
  } qbStrobe_t;

  // Status from the datapath back to control
  typedef struct packed {
    logic wrLast;     // write position is the final slot
    logic spanZero;   // block span is zero
    logic needZp;     // asymmetric block needs a zero-point division
    logic divDone;    // divider result ready
    logic rdLast;     // read position is the final slot
  } qbStatus_t;

  typedef enum logic [2:0] {
    S_COLLECT, S_PREP, S_ZP, S_META, S_CSTART, S_CWAIT, S_ZEMIT
  } qbState_t;

endpackage

// File: rtl/qb_divider.sv
module qb_divider #(
  parameter int NUM_W = 27,
  parameter int DEN_W = 18
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic             busy,
  output logic             done,
  output logic [NUM_W-1:0] quo
);
  localparam int CNT_W = $clog2(NUM_W);

  logic [NUM_W-1:0] numSh;
  logic [DEN_W-1:0] rem;
  logic [CNT_W-1:0] cnt;
  logic [DEN_W:0]   trial;
  logic [DEN_W:0]   diff;
  logic             qBit;

  always_comb begin
    trial = {rem, numSh[NUM_W-1]};
    diff  = trial - {1'b0, den};
    qBit  = (trial >= {1'b0, den});
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      numSh <= '0;
      rem   <= '0;
      cnt   <= '0;
      busy  <= 1'b0;
      done  <= 1'b0;
      quo   <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        numSh <= num;
        rem   <= '0;
        quo   <= '0;
        cnt   <= CNT_W'(NUM_W-1);
        busy  <= 1'b1;
      end else if (busy) begin
        rem   <= qBit ? diff[DEN_W-1:0] : trial[DEN_W-1:0];
        quo   <= {quo[NUM_W-2:0], qBit};
        numSh <= {numSh[NUM_W-2:0], 1'b0};
        cnt   <= cnt - 1'b1;
        if (cnt == '0) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  div_start_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    start |-> !busy);

  div_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(busy));

endmodule

// File: rtl/qb_datapath.sv
module qb_datapath import qb_pkg::*; #(
  parameter int BLOCK_LEN = 16,
  parameter int DATA_W    = 16,
  parameter int CODE_W    = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  qbStrobe_t                st,
  input  logic signed [DATA_W-1:0] inData,
  input  logic                     asymMode,
  output qbStatus_t                stat,
  output logic                     metaValid,
  output logic [DATA_W:0]          metaScale,
  output logic [CODE_W-1:0]        metaZero,
  output logic                     outValid,
  output logic [CODE_W-1:0]        outCode,
  output logic                     outLast
);
  localparam int IDX_W    = $clog2(BLOCK_LEN);
  localparam int MAG_W    = DATA_W + 1;
  localparam int NUM_W    = MAG_W + CODE_W + 2;
  localparam int DEN_W    = MAG_W + 1;
  localparam int SYM_TOP  = (1 << (CODE_W-1)) - 1;
  localparam int ASYM_TOP = (1 << CODE_W) - 1;

  logic signed [DATA_W-1:0] blockMem [BLOCK_LEN];
  logic [IDX_W-1:0]         wrIdx, rdIdx, wrPos;
  logic signed [DATA_W-1:0] curMin, curMax, elem;
  logic                     blkAsym;
  logic [CODE_W-1:0]        zpReg;

  logic signed [MAG_W-1:0]  minE, maxE, elemE;
  logic [MAG_W-1:0]         absMin, absMax, absElem, offElem, span, numOff;
  logic [NUM_W-1:0]         rangeTop2, divNum, divQuo, satTop;
  logic [DEN_W-1:0]         divDen;
  logic [CODE_W-1:0]        qSat, codeVal;
  logic                     divBusy, divDone;

  always_comb begin
    wrPos   = st.restart ? '0 : wrIdx;
    elem    = blockMem[rdIdx];
    minE    = {curMin[DATA_W-1], curMin};
    maxE    = {curMax[DATA_W-1], curMax};
    elemE   = {elem[DATA_W-1], elem};
    absMin  = minE[MAG_W-1]  ? MAG_W'(-minE)  : MAG_W'(minE);
    absMax  = maxE[MAG_W-1]  ? MAG_W'(-maxE)  : MAG_W'(maxE);
    absElem = elemE[MAG_W-1] ? MAG_W'(-elemE) : MAG_W'(elemE);
    offElem = MAG_W'(elemE - minE);
    if (blkAsym) span = MAG_W'(maxE - minE);
    else         span = (absMax > absMin) ? absMax : absMin;

    // Numerator: offset*2*top + span, denominator 2*span -> half-step rounding
    numOff    = st.startZp ? absMin : (blkAsym ? offElem : absElem);
    rangeTop2 = blkAsym ? NUM_W'(2*ASYM_TOP) : NUM_W'(2*SYM_TOP);
    divNum    = NUM_W'(numOff) * rangeTop2 + NUM_W'(span);
    divDen    = {span, 1'b0};

    satTop  = blkAsym ? NUM_W'(ASYM_TOP) : NUM_W'(SYM_TOP);
    qSat    = (divQuo > satTop) ? satTop[CODE_W-1:0] : divQuo[CODE_W-1:0];
    codeVal = (!blkAsym && elemE[MAG_W-1]) ? (CODE_W'(0) - qSat) : qSat;

    stat.wrLast   = (wrIdx == IDX_W'(BLOCK_LEN-1));
    stat.rdLast   = (rdIdx == IDX_W'(BLOCK_LEN-1));
    stat.spanZero = (span == '0);
    stat.needZp   = blkAsym && minE[MAG_W-1] && (span != '0);
    stat.divDone  = divDone;
  end

  qb_divider #(.NUM_W(NUM_W), .DEN_W(DEN_W)) u_div (
    .clk   (clk),
    .rstN  (rstN),
    .start (st.startZp | st.startCode),
    .num   (divNum),
    .den   (divDen),
    .busy  (divBusy),
    .done  (divDone),
    .quo   (divQuo)
  );

  always_ff @(posedge clk) begin
    if (st.capture) blockMem[wrPos] <= inData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrIdx     <= '0;
      rdIdx     <= '0;
      curMin    <= '0;
      curMax    <= '0;
      blkAsym   <= 1'b0;
      zpReg     <= '0;
      metaValid <= 1'b0;
      metaScale <= '0;
      metaZero  <= '0;
      outValid  <= 1'b0;
      outCode   <= '0;
      outLast   <= 1'b0;
    end else begin
      metaValid <= 1'b0;
      outValid  <= 1'b0;
      if (st.capture) begin
        wrIdx <= wrPos + 1'b1;
        if (st.restart) begin
          curMin  <= inData;
          curMax  <= inData;
          blkAsym <= asymMode;
        end else begin
          if (inData < curMin) curMin <= inData;
          if (inData > curMax) curMax <= inData;
        end
      end
      if (st.latchZp) zpReg <= qSat;
      if (st.emitMeta) begin
        metaValid <= 1'b1;
        metaScale <= span;
        metaZero  <= stat.needZp ? zpReg : '0;
        rdIdx     <= '0;
      end
      if (st.emitCode) begin
        outValid <= 1'b1;
        outCode  <= stat.spanZero ? '0 : codeVal;
        outLast  <= stat.rdLast;
        rdIdx    <= rdIdx + 1'b1;
      end
    end
  end

  // Checker state for ordering and count properties
  logic             metaSeen;
  logic [IDX_W:0]   codeCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      metaSeen <= 1'b0;
      codeCnt  <= '0;
    end else begin
      if (metaValid) begin
        metaSeen <= 1'b1;
        codeCnt  <= '0;
      end else if (outValid) begin
        codeCnt <= codeCnt + 1'b1;
        if (outLast) metaSeen <= 1'b0;
      end
    end
  end

  // R3
  sym_code_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !blkAsym) |-> (outCode != {1'b1, {(CODE_W-1){1'b0}}}));

  // R9
  meta_before_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> metaSeen);

  // R9
  last_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outLast) |-> (codeCnt == (IDX_W+1)'(BLOCK_LEN-1)));

  // R6
  zero_scale_chk: assert property (@(posedge clk) disable iff (!rstN)
    (metaValid && metaScale == '0) |-> (metaZero == '0));

endmodule

// File: rtl/qb_ctrl.sv
module qb_ctrl import qb_pkg::*; (
  input  logic      clk,
  input  logic      rstN,
  input  logic      inValid,
  input  logic      inFirst,
  input  qbStatus_t stat,
  output qbStrobe_t st,
  output logic      inReady
);
  qbState_t state, nextState;
  logic     blkOpen, nextOpen;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_COLLECT;
      blkOpen <= 1'b0;
    end else begin
      state   <= nextState;
      blkOpen <= nextOpen;
    end
  end

  always_comb begin
    st        = '0;
    nextState = state;
    nextOpen  = blkOpen;
    inReady   = 1'b0;
    unique case (state)
      S_COLLECT: begin
        inReady = 1'b1;
        if (inValid) begin
          if (inFirst) begin
            st.capture = 1'b1;
            st.restart = 1'b1;
            nextOpen   = 1'b1;
          end else if (blkOpen) begin
            st.capture = 1'b1;
            if (stat.wrLast) begin
              nextOpen  = 1'b0;
              nextState = S_PREP;
            end
          end
        end
      end
      S_PREP: begin
        if (!stat.spanZero && stat.needZp) begin
          st.startZp = 1'b1;
          nextState  = S_ZP;
        end else begin
          nextState = S_META;
        end
      end
      S_ZP: begin
        if (stat.divDone) begin
          st.latchZp = 1'b1;
          nextState  = S_META;
        end
      end
      S_META: begin
        st.emitMeta = 1'b1;
        nextState   = stat.spanZero ? S_ZEMIT : S_CSTART;
      end
      S_CSTART: begin
        st.startCode = 1'b1;
        nextState    = S_CWAIT;
      end
      S_CWAIT: begin
        if (stat.divDone) begin
          st.emitCode = 1'b1;
          nextState   = stat.rdLast ? S_COLLECT : S_CSTART;
        end
      end
      S_ZEMIT: begin
        st.emitCode = 1'b1;
        if (stat.rdLast) nextState = S_COLLECT;
      end
      default: nextState = S_COLLECT;
    endcase
  end

endmodule

// File: rtl/block_quantizer.sv
module block_quantizer import qb_pkg::*; #(
  parameter int BLOCK_LEN = 16,
  parameter int DATA_W    = 16,
  parameter int CODE_W    = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              asymMode,
  input  logic              inValid,
  input  logic              inFirst,
  input  logic [DATA_W-1:0] inData,
  output logic              inReady,
  output logic              metaValid,
  output logic [DATA_W:0]   metaScale,
  output logic [CODE_W-1:0] metaZero,
  output logic              outValid,
  output logic [CODE_W-1:0] outCode,
  output logic              outLast
);
  qbStrobe_t st;
  qbStatus_t stat;

  qb_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .inFirst (inFirst),
    .stat    (stat),
    .st      (st),
    .inReady (inReady)
  );

  qb_datapath #(
    .BLOCK_LEN (BLOCK_LEN),
    .DATA_W    (DATA_W),
    .CODE_W    (CODE_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .st        (st),
    .inData    ($signed(inData)),
    .asymMode  (asymMode),
    .stat      (stat),
    .metaValid (metaValid),
    .metaScale (metaScale),
    .metaZero  (metaZero),
    .outValid  (outValid),
    .outCode   (outCode),
    .outLast   (outLast)
  );

  // R10
  drain_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    (metaValid || (outValid && !outLast)) |-> !inReady);

endmodule

// File: tb/block_quantizer_bench.sv
module block_quantizer_bench;
  localparam int BLK = 16;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        asymMode = 1'b0;
  logic        inValid = 1'b0;
  logic        inFirst = 1'b0;
  logic [15:0] inData = '0;
  logic        inReady, metaValid, outValid, outLast;
  logic [16:0] metaScale;
  logic [7:0]  metaZero, outCode;

  int  nChecks = 0;
  int  nFails  = 0;
  bit  finished = 0;
  int  vals [BLK];

  block_quantizer #(.BLOCK_LEN(BLK)) u_block_quantizer (
    .clk(clk), .rstN(rstN), .asymMode(asymMode), .inValid(inValid),
    .inFirst(inFirst), .inData(inData), .inReady(inReady),
    .metaValid(metaValid), .metaScale(metaScale), .metaZero(metaZero),
    .outValid(outValid), .outCode(outCode), .outLast(outLast)
  );

  always #10 clk = ~clk;

  task automatic check(string req, string what, longint act, longint exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic longint symCode(longint x, longint amax);
    longint mag, q;
    if (amax == 0) return 0;
    mag = (x < 0) ? -x : x;
    q = (mag * 254 + amax) / (2 * amax);
    if (q > 127) q = 127;
    return (x < 0) ? -q : q;
  endfunction

  function automatic longint asymCode(longint x, longint mn, longint span);
    longint q;
    if (span == 0) return 0;
    q = ((x - mn) * 510 + span) / (2 * span);
    return (q > 255) ? 255 : q;
  endfunction

  function automatic longint zeroPoint(longint mn, longint span);
    longint q;
    if (span == 0 || mn >= 0) return 0;
    q = ((-mn) * 510 + span) / (2 * span);
    return (q > 255) ? 255 : q;
  endfunction

  task automatic feedElem(int v, bit first, bit mode);
    @(negedge clk);
    while (!inReady) @(negedge clk);
    inValid  = 1'b1;
    inData   = 16'(v);
    inFirst  = first;
    asymMode = mode;
    @(posedge clk);
    #1;
    inValid = 1'b0;
    inFirst = 1'b0;
  endtask

  // Feeds vals[] as one block (mode on element 0, inverted mode afterwards)
  task automatic runBlock(bit mode, string scaleTag);
    longint mn, mx, amax, span, expCode, act;
    int     idx;
    bit     metaGot, drainOk, firstCyc, done;
    string  codeTag;
    mn = vals[0]; mx = vals[0];
    for (int i = 1; i < BLK; i++) begin
      if (vals[i] < mn) mn = vals[i];
      if (vals[i] > mx) mx = vals[i];
    end
    amax = ((-mn) > mx) ? -mn : mx;
    if (amax < 0) amax = -amax;
    span = mode ? (mx - mn) : amax;
    if (scaleTag == "") scaleTag = (span == 0) ? "R6" : (mode ? "R4" : "R2");
    codeTag = (span == 0) ? "R6" : (mode ? "R4" : "R2");

    for (int i = 0; i < BLK; i++)
      feedElem(vals[i], i == 0, (i == 0) ? mode : !mode);   // R7

    idx = 0; metaGot = 0; drainOk = 1; firstCyc = 1; done = 0;
    while (!done) begin
      @(negedge clk);
      if (firstCyc) begin
        check("R10", "inReady after final element", longint'(inReady), 0);
        firstCyc = 0;
      end
      if (metaValid) begin
        check("R9", "meta precedes codes", longint'(idx), 0);
        check(scaleTag, "metaScale", longint'(metaScale), span);
        check(mode ? "R5" : "R2", "metaZero", longint'(metaZero),
              mode ? zeroPoint(mn, span) : 0);
        metaGot = 1;
      end
      if ((metaValid || (outValid && !outLast)) && inReady) drainOk = 0;
      if (outValid) begin
        if (mode) begin
          expCode = asymCode(vals[idx], mn, span);
          act = longint'(outCode);
        end else begin
          expCode = symCode(vals[idx], amax);
          act = longint'($signed(outCode));
          if (outCode == 8'h80) check("R3", "code -128 produced", act, -127);
        end
        check(codeTag, $sformatf("code[%0d]", idx), act, expCode);
        check("R9", "outLast position", longint'(outLast), longint'(idx == BLK-1));
        idx++;
        if (outLast) done = 1;
      end
    end
    check("R9", "meta pulse seen", longint'(metaGot), 1);
    check("R9", "code count", longint'(idx), BLK);
    check("R10", "inReady low while draining", longint'(drainOk), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nFails++;
      $display("FAIL R9 watchdog: actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R11", "inReady after reset", longint'(inReady), 1);
    check("R11", "metaValid after reset", longint'(metaValid), 0);
    check("R11", "outValid after reset", longint'(outValid), 0);

    // R1: stray elements before any open block are dropped
    feedElem(20000, 0, 0);
    feedElem(-31000, 0, 0);
    for (int i = 0; i < BLK; i++) vals[i] = i * 3 - 20;
    runBlock(0, "R1");

    // R6: zero span blocks
    for (int i = 0; i < BLK; i++) vals[i] = 0;
    runBlock(0, "R6");
    runBlock(1, "R6");
    for (int i = 0; i < BLK; i++) vals[i] = 500;
    runBlock(1, "R6");

    // R2: half-step rounding, away from zero
    for (int i = 0; i < BLK; i++) vals[i] = 0;
    vals[0] = 254; vals[1] = 1; vals[2] = -1; vals[3] = 3; vals[4] = -3; vals[5] = -254;
    runBlock(0, "R2");

    // R3: most negative input in symmetric mode
    for (int i = 0; i < BLK; i++) vals[i] = (i % 2 == 0) ? -32768 : 32767 - i;
    runBlock(0, "R3");

    // R4/R5: full-range asymmetric
    for (int i = 0; i < BLK; i++) vals[i] = -32768 + i * 4369;
    vals[BLK-1] = 32767;
    runBlock(1, "R4");

    // R5: all positive and all negative asymmetric blocks
    for (int i = 0; i < BLK; i++) vals[i] = 100 + i * 37;
    runBlock(1, "R5");
    for (int i = 0; i < BLK; i++) vals[i] = -100 - i * 37;
    runBlock(1, "R5");

    // R8: outlier block then small block
    for (int i = 0; i < BLK; i++) vals[i] = i - 8;
    vals[7] = 32000;
    runBlock(0, "R8");
    for (int i = 0; i < BLK; i++) vals[i] = i - 8;
    runBlock(0, "R8");

    // R1: restart discards a partial block
    feedElem(30000, 1, 1);
    for (int i = 0; i < 5; i++) feedElem(-29000 + i, 0, 1);
    for (int i = 0; i < BLK; i++) vals[i] = 40 - i * 5;
    runBlock(0, "R1");

    // Random blocks
    for (int b = 0; b < 40; b++) begin
      bit mode;
      int shift;
      mode  = 1'($urandom % 2);
      shift = int'($urandom % 16);
      for (int i = 0; i < BLK; i++)
        vals[i] = int'($signed(16'($urandom))) >>> shift;
      if ($urandom % 4 == 0) vals[$urandom % BLK] = ($urandom % 2) ? 32767 : -32768;
      runBlock(mode, "");
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule